// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

This unit sits beside the bit-level engine of a CAN FD controller. During the fast data phase, the round trip through the transceiver can take longer than a data bit. The normal sample point would then see a stale level. The unit measures that loop delay once per frame, in system clock cycles. The delay runs from the first dominant edge the node transmits after the data phase begins to the same edge returning on the RX line. From then on, each transmitted bit is checked against the received line at a secondary sample point. That point lies the measured delay plus a programmed offset after the bit start.

The controller supplies a one-cycle bit-start strobe for every data-phase bit, a phase flag, the local TX stream, the RX line and a configuration word. In the configuration word, bits [7:0] hold the data prescaler minus one, bits [14:8] hold the offset and bit 16 is the enable. Compensation is active only when bit 16 is 1 and the prescaler field is 0 or 1. The measured delay can be read but never written.

At each secondary sample the unit emits a strobe and the sampled RX level. It also raises a single-cycle error when the sampled RX level differs from the TX level present at the start of that bit.

Top module: `tdc_unit`

## Requirements
- R1: After reset, ssp_strobe, bit_err, ssp_rx, delay_val and delay_timeout are all 0.
- R2: When the data phase is entered (data_phase sampled 1 after 0) with compensation active, delay_val becomes the number of cycles from the sampled TX falling edge to the sampled RX falling edge. The update appears in the same cycle as the RX falling edge, and a simultaneous fall gives 0.
- R3: If no RX falling edge arrives within 127 cycles of the TX falling edge, delay_val saturates at 127 and delay_timeout is set. delay_timeout is cleared when the next active data phase is entered.
- R4: ssp_strobe pulses exactly P cycles after a sampled bit_start, where P is delay_val plus the effective offset. With P = 0, the strobe follows the bit_start edge directly.
- R5: On each strobe, ssp_rx holds the RX level sampled in the strobe cycle.
- R6: bit_err pulses with a strobe, and only then, when that RX level differs from the TX level sampled with the matching bit_start.
- R7: With enable (bit 16) at 0 or a prescaler field (bits [7:0]) above 1, no strobe or error is produced and delay_val and delay_timeout hold.
- R8: While data_phase is 0, no strobe or error is produced and delay_val holds.
- R9: Only the first TX falling edge of each data phase is measured. Later edges in the same frame leave delay_val unchanged.
- R10: An offset field value above 64 acts as 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | [7:0] prescaler-1, [14:8] offset, [16] enable |
| data_phase | input | 1 | 1 during the data phase |
| bit_start | input | 1 | One-cycle strobe at each data bit start |
| tx_bit | input | 1 | Local transmit level |
| rx_bit | input | 1 | Received bus level |
| ssp_strobe | output | 1 | Secondary sample strobe |
| ssp_rx | output | 1 | RX level taken at the last strobe |
| bit_err | output | 1 | One-cycle mismatch flag |
| delay_val | output | 7 | Measured loop delay in cycles |
| delay_timeout | output | 1 | Measurement ran out at 127 cycles |

## Verification
The hardest situation to reach is a secondary sample point that lies further back than one bit length. In that case several bits are in flight between their start and their check, and the check must pick the right TX history entry. The stimulus covers this with short bits against long delays plus offsets, including saturated 127-cycle delays after a timeout frame. It also flips RX for single cycles late in each frame, so that mismatches land on some strobes and not on others.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // configuration word layout (fixed by the software interface)
  localparam int CFG_W       = 32;
  localparam int PRE_LSB     = 0;
  localparam int PRE_W       = 8;
  localparam int OFS_LSB     = 8;
  localparam int OFS_FIELD_W = 7;
  localparam int EN_BIT      = 16;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ARM,
    MS_COUNT,
    MS_DONE
  } meas_state_t;
endpackage

// File: rtl/tdc_cfg_decode.sv
module tdc_cfg_decode
  import tdc_pkg::*;
#(
  parameter int OFS_W   = 7,
  parameter int OFS_MAX = 64
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic             active,
  output logic [OFS_W-1:0] ofs_eff
);
  logic [PRE_W-1:0]       pre_field;
  logic [OFS_FIELD_W-1:0] ofs_field;

  assign pre_field = cfg_word[PRE_LSB +: PRE_W];
  assign ofs_field = cfg_word[OFS_LSB +: OFS_FIELD_W];

  // compensation only at prescaler 1 or 2 (field 0 or 1)
  assign active = cfg_word[EN_BIT] && (pre_field <= PRE_W'(1));

  always_comb begin
    if (int'(ofs_field) > OFS_MAX) ofs_eff = OFS_W'(OFS_MAX);
    else                           ofs_eff = OFS_W'(ofs_field);
  end
endmodule

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas
  import tdc_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             data_phase,
  input  logic             tx_bit,
  input  logic             rx_bit,
  output logic [DLY_W-1:0] delay_o,
  output logic             timeout_o
);
  localparam logic [DLY_W-1:0] DLY_SAT = {DLY_W{1'b1}};

  meas_state_t      state;
  logic [DLY_W-1:0] cnt;
  logic             tx_q, rx_q, dp_q;
  logic             tx_fall, rx_fall;

  assign tx_fall = tx_q & ~tx_bit;
  assign rx_fall = rx_q & ~rx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_IDLE;
      cnt       <= '0;
      delay_o   <= '0;
      timeout_o <= 1'b0;
      tx_q      <= 1'b1;
      rx_q      <= 1'b1;
      dp_q      <= 1'b0;
    end else begin
      tx_q <= tx_bit;
      rx_q <= rx_bit;
      dp_q <= data_phase;
      if (!data_phase || !active) begin
        state <= MS_IDLE;
      end else begin
        unique case (state)
          MS_IDLE: begin
            if (!dp_q) begin
              state     <= MS_ARM;
              timeout_o <= 1'b0;
            end
          end
          MS_ARM: begin
            if (tx_fall) begin
              if (rx_fall) begin
                delay_o <= '0;
                state   <= MS_DONE;
              end else begin
                cnt   <= DLY_W'(1);
                state <= MS_COUNT;
              end
            end
          end
          MS_COUNT: begin
            if (rx_fall) begin
              delay_o <= cnt;
              state   <= MS_DONE;
            end else if (cnt == DLY_SAT) begin
              delay_o   <= DLY_SAT;
              timeout_o <= 1'b1;
              state     <= MS_DONE;
            end else begin
              cnt <= cnt + DLY_W'(1);
            end
          end
          default: state <= MS_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdc_ssp_gen.sv
module tdc_ssp_gen #(
  parameter int DLY_W    = 7,
  parameter int OFS_W    = 7,
  parameter int HIST_LEN = 191
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             data_phase,
  input  logic             bit_start,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             ssp_strobe,
  output logic             ssp_rx,
  output logic             bit_err
);
  localparam int PW = $clog2(HIST_LEN + 1);

  // index 0 = current input, index k = sampled k cycles earlier
  logic [HIST_LEN-1:0] h_start, h_tx;
  logic [HIST_LEN:0]   v_start, v_tx;
  logic [PW-1:0]       pos;
  logic                hit, ref_tx, fire;

  assign v_start = {h_start, bit_start};
  assign v_tx    = {h_tx, tx_bit};
  assign pos     = PW'(delay_i) + PW'(ofs_i);
  assign hit     = v_start[pos];
  assign ref_tx  = v_tx[pos];
  assign fire    = active && data_phase && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_start    <= '0;
      h_tx       <= '0;
      ssp_strobe <= 1'b0;
      ssp_rx     <= 1'b0;
      bit_err    <= 1'b0;
    end else begin
      h_start    <= v_start[HIST_LEN-1:0];
      h_tx       <= v_tx[HIST_LEN-1:0];
      ssp_strobe <= fire;
      bit_err    <= fire && (rx_bit != ref_tx);
      if (fire) ssp_rx <= rx_bit;
    end
  end
endmodule

// File: rtl/tdc_unit.sv
module tdc_unit
  import tdc_pkg::*;
#(
  parameter int DLY_W   = 7,
  parameter int OFS_W   = 7,
  parameter int OFS_MAX = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             data_phase,
  input  logic             bit_start,
  input  logic             tx_bit,
  input  logic             rx_bit,
  output logic             ssp_strobe,
  output logic             ssp_rx,
  output logic             bit_err,
  output logic [DLY_W-1:0] delay_val,
  output logic             delay_timeout
);
  localparam int DLY_MAX  = (1 << DLY_W) - 1;
  localparam int HIST_LEN = DLY_MAX + OFS_MAX;

  logic             active;
  logic [OFS_W-1:0] ofs_eff;

  tdc_cfg_decode #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX)) u_cfg (
    .cfg_word (cfg_word),
    .active   (active),
    .ofs_eff  (ofs_eff)
  );

  tdc_delay_meas #(.DLY_W(DLY_W)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .data_phase (data_phase),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .delay_o    (delay_val),
    .timeout_o  (delay_timeout)
  );

  tdc_ssp_gen #(.DLY_W(DLY_W), .OFS_W(OFS_W), .HIST_LEN(HIST_LEN)) u_ssp (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .data_phase (data_phase),
    .bit_start  (bit_start),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .delay_i    (delay_val),
    .ofs_i      (ofs_eff),
    .ssp_strobe (ssp_strobe),
    .ssp_rx     (ssp_rx),
    .bit_err    (bit_err)
  );
endmodule

// File: rtl/tdc_unit_chk.sv
module tdc_unit_chk #(
  parameter int DLY_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      cfg_word,
  input logic             data_phase,
  input logic             bit_start,
  input logic             rx_bit,
  input logic             ssp_strobe,
  input logic             ssp_rx,
  input logic             bit_err,
  input logic [DLY_W-1:0] delay_val,
  input logic             delay_timeout
);
  logic cfg_on;
  assign cfg_on = cfg_word[16] && (cfg_word[7:0] <= 8'd1);

  a_r7_quiet_inactive: assert property (@(posedge clk) disable iff (rst)
    !cfg_on |=> !ssp_strobe && !bit_err);

  a_r7_delay_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_on |=> $stable(delay_val) && $stable(delay_timeout));

  a_r8_quiet_arbitration: assert property (@(posedge clk) disable iff (rst)
    !data_phase |=> !ssp_strobe && $stable(delay_val));

  a_r6_err_with_strobe: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> ssp_strobe);

  a_r3_timeout_saturated: assert property (@(posedge clk) disable iff (rst)
    delay_timeout |-> (delay_val == {DLY_W{1'b1}}));

  a_r5_rx_captured: assert property (@(posedge clk) disable iff (rst)
    ssp_strobe |-> (ssp_rx == $past(rx_bit)));

  a_r4_zero_position: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && data_phase && bit_start && delay_val == '0 && cfg_word[14:8] == 7'd0)
      |=> ssp_strobe);
endmodule

bind tdc_unit tdc_unit_chk #(.DLY_W(DLY_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_word      (cfg_word),
  .data_phase    (data_phase),
  .bit_start     (bit_start),
  .rx_bit        (rx_bit),
  .ssp_strobe    (ssp_strobe),
  .ssp_rx        (ssp_rx),
  .bit_err       (bit_err),
  .delay_val     (delay_val),
  .delay_timeout (delay_timeout)
);

// File: tb/tdc_unit_tb.sv
module tdc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        data_phase = 1'b0;
  logic        bit_start = 1'b0;
  logic        tx_bit = 1'b1;
  logic        rx_bit = 1'b1;
  logic        ssp_strobe, ssp_rx, bit_err, delay_timeout;
  logic [6:0]  delay_val;

  always #5 clk = ~clk;

  tdc_unit u_dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .data_phase(data_phase),
    .bit_start(bit_start), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .ssp_strobe(ssp_strobe), .ssp_rx(ssp_rx), .bit_err(bit_err),
    .delay_val(delay_val), .delay_timeout(delay_timeout)
  );

  int unsigned checks = 0, errors = 0;
  bit          done = 0;

  // reference model state
  int          cyc = 0;
  int          md = 0;
  bit          mto = 0;
  int          upd_cyc = -1;
  int          upd_val = 0;
  bit          upd_to = 0;
  int          cur_d = 0;
  bit          hold_rx = 0;
  bit          act = 0;
  int          offc = 0;
  logic [255:0] txsh = '1, hst = '0, htx = '0;

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at step %0d: actual %0d expected %0d", tag, cyc, actv, expv);
    end
  endtask

  // one clock step: drive at negedge, let the edge sample, check at next negedge
  task automatic step(input bit st, input bit tx, input bit dp, input bit flip, input bit entry);
    bit r, es, ee;
    int p;
    txsh = {txsh[254:0], tx};
    r = (hold_rx && dp) ? 1'b1 : txsh[cur_d];
    r = r ^ flip;
    bit_start = st; tx_bit = tx; data_phase = dp; rx_bit = r;
    hst = {hst[254:0], st};
    htx = {htx[254:0], tx};
    p  = md + offc;
    es = act && dp && hst[p];
    ee = es && (r != htx[p]);
    @(posedge clk);
    if (cyc == upd_cyc) begin md = upd_val; mto = upd_to; end
    if (entry && act) mto = 0;
    @(negedge clk);
    chk(ssp_strobe == es, "R4 R7 R8 strobe", ssp_strobe, es);
    chk(bit_err == ee, "R6 bit_err", bit_err, ee);
    if (es) chk(ssp_rx == r, "R5 ssp_rx", ssp_rx, r);
    chk(delay_val == md, "R2 R9 delay_val", delay_val, md);
    chk(delay_timeout == mto, "R3 timeout", delay_timeout, mto);
    cyc++;
  endtask

  task automatic frame(input bit en, input int pre, input int off, input int d,
                       input bit tmo, input int blen);
    int  nbits, k;
    bit  v, started;
    cfg_word = '0;
    cfg_word[7:0]  = pre[7:0];
    cfg_word[14:8] = off[6:0];
    cfg_word[16]   = en;
    act     = en && (pre <= 1);
    offc    = (off > 64) ? 64 : off;   // R10 clamp in the model
    cur_d   = d;
    hold_rx = tmo;
    nbits   = 260 / blen + 2;
    // arbitration: toggling bits must cause nothing (R8)
    for (int i = 0; i < 10; i++) step((i % 3) == 0, 1'($urandom % 2), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    k = 0; started = 0;
    for (int b = 0; b < nbits; b++) begin
      v = (b == 0) ? 1'b0 : 1'($urandom % 2);
      for (int c = 0; c < blen; c++) begin
        bit fl;
        if (!started) begin
          started = 1;
          k = cyc;
          if (act) begin
            upd_cyc = k + (tmo ? 127 : d);
            upd_val = tmo ? 127 : d;
            upd_to  = tmo;
          end else begin
            upd_cyc = -1;
          end
        end
        fl = !tmo && (cyc - k > 150) && ($urandom % 16 == 0);
        step(c == 0, v, 1'b1, fl, 1'b0);
      end
    end
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    hold_rx = 0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20517);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ssp_strobe == 0, "R1 strobe", ssp_strobe, 0);
    chk(bit_err == 0, "R1 bit_err", bit_err, 0);
    chk(ssp_rx == 0, "R1 ssp_rx", ssp_rx, 0);
    chk(delay_val == 0, "R1 delay_val", delay_val, 0);
    chk(delay_timeout == 0, "R1 timeout", delay_timeout, 0);
    // directed corners
    frame(1, 0, 12, 9, 0, 16);    // R4: 9 + 12 = 21 cycles, longer than a bit
    frame(1, 1, 0, 0, 0, 8);      // R2/R4: zero delay, zero offset
    frame(1, 0, 64, 30, 0, 5);    // R4: largest offset, many bits in flight
    frame(1, 1, 100, 20, 0, 6);   // R10: offset 100 acts as 64
    frame(1, 0, 5, 0, 1, 10);     // R3: no RX edge, saturate to 127
    frame(1, 0, 7, 15, 0, 12);    // R3: next active frame clears timeout
    frame(0, 0, 10, 25, 0, 9);    // R7: disabled, delay holds at 15
    frame(1, 2, 10, 25, 0, 9);    // R7: prescaler field 2 is too large
    frame(1, 1, 3, 40, 0, 4);     // R9: many later falls, first one counts
    frame(1, 0, 90, 1, 1, 7);     // R3/R10: 127 + 64 furthest position
    // random frames
    for (int f = 0; f < 12; f++) begin
      bit en; int pre;
      en  = ($urandom % 5) != 0;
      pre = ($urandom % 4 == 0) ? (2 + $urandom % 254) : ($urandom % 2);
      frame(en, pre, $urandom % 128, $urandom % 61, ($urandom % 6) == 0, 4 + $urandom % 20);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule